// File: doc/BRIEF.md
# Four-Phase Return-to-Zero Channel Between Two Clock Domains

This block moves single data words from a producing module to a consuming module when the two run on clocks with no fixed relation. It is a push channel: a write-side controller in the producer's clock domain and a read-side controller in the consumer's clock domain share one request wire, one acknowledge wire and a bundled data bus. Only the write side ever raises the request. The read side only answers.

Each side is armed on its own by a one-cycle pulse from its local module, and every arming completes exactly one transfer. The write side latches the word, drives it onto the bus one cycle before it raises the request, and keeps its module stalled until the acknowledge has risen and fallen again. The read side waits, once armed, for a request. It captures the bus as it raises the acknowledge and gives its module a one-cycle done pulse together with the captured word. Each controller passes the wire coming from the other domain through a two-flop synchroniser before acting on it.

Top module: `hs4_channel`

## Requirements
- R1: A transfer runs request high, acknowledge high, request low, acknowledge low. The request rises only while the write side sees the acknowledge low, and it falls only after the write side has seen the acknowledge high.
- R2: The acknowledge rises only while the read side sees the request high, and it falls only after the read side has seen the request low.
- R3: The bus holds the latched word from the cycle before the request rises until the write side sees the acknowledge low again. The word on `rd_word` after a transfer equals the word given with the `wr_go` pulse.
- R4: A `wr_go` pulse is accepted only while `wr_busy` is low. A pulse given during a transfer starts no second transfer and does not change the word being sent.
- R5: An unarmed read side never raises the acknowledge, so the write side stays busy. An armed read side stays armed for any length of time until a request arrives.
- R6: `wr_busy` is high from the cycle after an accepted `wr_go` until the transfer ends, and it is high whenever the request is high.
- R7: `wr_done` is a one-cycle pulse after the write side sees the acknowledge fall. `rd_done` is a one-cycle pulse in the cycle the new word appears on `rd_word`, while the acknowledge is high.
- R8: While `wr_rst` and `rd_rst` (synchronous, active high) are applied, the request, the acknowledge, `wr_busy`, both done pulses and `rd_word` are all low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Producer clock |
| wr_rst | input | 1 | Producer-domain synchronous reset, active high |
| wr_go | input | 1 | One-cycle pulse: send `wr_word` |
| wr_word | input | WIDTH | Word to send, sampled with `wr_go` |
| wr_busy | output | 1 | Producer stall: a transfer is in progress |
| wr_done | output | 1 | One-cycle pulse: transfer finished on the write side |
| rd_clk | input | 1 | Consumer clock |
| rd_rst | input | 1 | Consumer-domain synchronous reset, active high |
| rd_arm | input | 1 | One-cycle pulse: accept one word |
| rd_word | output | WIDTH | Last captured word |
| rd_done | output | 1 | One-cycle pulse: `rd_word` holds a new word |
| chan_req | output | 1 | Channel request wire (write-side register) |
| chan_ack | output | 1 | Channel acknowledge wire (read-side register) |

## Verification
The checker assumes both resets are applied from time zero and held together for several cycles of the slower clock. It also assumes that neither reset is applied again in the middle of a transfer, because a one-sided reset would drop one wire while the other domain still holds the opposite one. The bench applies resets only at the start. It drives `wr_go` and `rd_arm` as single-cycle pulses on the falling edge of their own clocks, with the two clock periods chosen with no common ratio so that the synchronisers see both fast and slow arrivals. The data-stability property takes for granted that `wr_word` matters only in the cycle of an accepted pulse. The bench changes `wr_word` freely while a transfer is in progress to show that the bus does not follow it.

// File: rtl/hs4_pkg.sv
package hs4_pkg;

    typedef enum logic [1:0] {
        WP_IDLE,
        WP_LOAD,
        WP_RAISE,
        WP_DROP
    } wp_state_e;

    typedef enum logic [1:0] {
        RP_IDLE,
        RP_ARMED,
        RP_HOLD
    } rp_state_e;

    localparam int unsigned SYNC_STAGES_DEFAULT = 2;

    function automatic logic wp_active(input wp_state_e s);
        return s != WP_IDLE;
    endfunction

endpackage

// File: rtl/hs4_sync.sv
module hs4_sync #(
    parameter int unsigned STAGES = hs4_pkg::SYNC_STAGES_DEFAULT
) (
    input  logic clk,
    input  logic rst,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] chain;

    for (genvar i = 0; i < STAGES; i++) begin : g_stage
        if (i == 0) begin : g_first
            always_ff @(posedge clk) begin
                if (rst) chain[0] <= 1'b0;
                else     chain[0] <= d;
            end
        end else begin : g_next
            always_ff @(posedge clk) begin
                if (rst) chain[i] <= 1'b0;
                else     chain[i] <= chain[i-1];
            end
        end
    end

    assign q = chain[STAGES-1];
endmodule

// File: rtl/hs4_wport.sv
module hs4_wport
    import hs4_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             go,
    input  logic [WIDTH-1:0] word,
    input  logic             ack_s,
    output logic             busy,
    output logic             done,
    output logic             req,
    output logic [WIDTH-1:0] bus
);
    wp_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= WP_IDLE;
            req   <= 1'b0;
            done  <= 1'b0;
            bus   <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                WP_IDLE: begin
                    if (go) begin
                        bus   <= word;
                        state <= WP_LOAD;
                    end
                end
                WP_LOAD: begin
                    if (!ack_s) begin
                        req   <= 1'b1;
                        state <= WP_RAISE;
                    end
                end
                WP_RAISE: begin
                    if (ack_s) begin
                        req   <= 1'b0;
                        state <= WP_DROP;
                    end
                end
                WP_DROP: begin
                    if (!ack_s) begin
                        done  <= 1'b1;
                        state <= WP_IDLE;
                    end
                end
                default: state <= WP_IDLE;
            endcase
        end
    end

    assign busy = wp_active(state);
endmodule

// File: rtl/hs4_rport.sv
module hs4_rport
    import hs4_pkg::*;
#(
    parameter int unsigned WIDTH = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             arm,
    input  logic             req_s,
    input  logic [WIDTH-1:0] bus,
    output logic             ack,
    output logic             done,
    output logic [WIDTH-1:0] word
);
    rp_state_e state;

    always_ff @(posedge clk) begin
        if (rst) begin
            state <= RP_IDLE;
            ack   <= 1'b0;
            done  <= 1'b0;
            word  <= '0;
        end else begin
            done <= 1'b0;
            case (state)
                RP_IDLE: begin
                    if (arm) state <= RP_ARMED;
                end
                RP_ARMED: begin
                    if (req_s) begin
                        word  <= bus;
                        ack   <= 1'b1;
                        done  <= 1'b1;
                        state <= RP_HOLD;
                    end
                end
                RP_HOLD: begin
                    if (!req_s) begin
                        ack   <= 1'b0;
                        state <= RP_IDLE;
                    end
                end
                default: state <= RP_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/hs4_channel.sv
module hs4_channel #(
    parameter int unsigned WIDTH       = 16,
    parameter int unsigned SYNC_STAGES = hs4_pkg::SYNC_STAGES_DEFAULT
) (
    input  logic             wr_clk,
    input  logic             wr_rst,
    input  logic             wr_go,
    input  logic [WIDTH-1:0] wr_word,
    output logic             wr_busy,
    output logic             wr_done,
    input  logic             rd_clk,
    input  logic             rd_rst,
    input  logic             rd_arm,
    output logic [WIDTH-1:0] rd_word,
    output logic             rd_done,
    output logic             chan_req,
    output logic             chan_ack
);
    logic             req_w;
    logic             ack_w;
    logic [WIDTH-1:0] bus_w;
    logic             ack_at_wr;
    logic             req_at_rd;

    hs4_sync #(.STAGES(SYNC_STAGES)) u_ack_sync (
        .clk (wr_clk),
        .rst (wr_rst),
        .d   (ack_w),
        .q   (ack_at_wr)
    );

    hs4_sync #(.STAGES(SYNC_STAGES)) u_req_sync (
        .clk (rd_clk),
        .rst (rd_rst),
        .d   (req_w),
        .q   (req_at_rd)
    );

    hs4_wport #(.WIDTH(WIDTH)) u_wport (
        .clk   (wr_clk),
        .rst   (wr_rst),
        .go    (wr_go),
        .word  (wr_word),
        .ack_s (ack_at_wr),
        .busy  (wr_busy),
        .done  (wr_done),
        .req   (req_w),
        .bus   (bus_w)
    );

    hs4_rport #(.WIDTH(WIDTH)) u_rport (
        .clk   (rd_clk),
        .rst   (rd_rst),
        .arm   (rd_arm),
        .req_s (req_at_rd),
        .bus   (bus_w),
        .ack   (ack_w),
        .done  (rd_done),
        .word  (rd_word)
    );

    assign chan_req = req_w;
    assign chan_ack = ack_w;
endmodule

// File: rtl/hs4_channel_chk.sv
module hs4_channel_chk #(
    parameter int unsigned WIDTH = 16
) (
    input logic             wr_clk,
    input logic             wr_rst,
    input logic             rd_clk,
    input logic             rd_rst,
    input logic             req,
    input logic             ack,
    input logic             ack_s,
    input logic             req_s,
    input logic [WIDTH-1:0] bus,
    input logic             wr_busy,
    input logic             wr_done,
    input logic             rd_done
);
    assert_req_rise_idle_R1: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $rose(req) |-> !ack_s);

    assert_req_fall_seen_R1: assert property (@(posedge wr_clk) disable iff (wr_rst)
        $fell(req) |-> ack_s);

    assert_ack_rise_seen_R2: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $rose(ack) |-> req_s);

    assert_ack_fall_seen_R2: assert property (@(posedge rd_clk) disable iff (rd_rst)
        $fell(ack) |-> !req_s);

    assert_bus_stable_R3: assert property (@(posedge wr_clk) disable iff (wr_rst)
        ($past(req || ack_s) && (req || ack_s)) |-> $stable(bus));

    assert_busy_with_req_R6: assert property (@(posedge wr_clk) disable iff (wr_rst)
        req |-> wr_busy);

    assert_wr_done_pulse_R7: assert property (@(posedge wr_clk) disable iff (wr_rst)
        wr_done |=> !wr_done);

    assert_rd_done_ack_R7: assert property (@(posedge rd_clk) disable iff (rd_rst)
        rd_done |-> ack);
endmodule

bind hs4_channel hs4_channel_chk #(.WIDTH(WIDTH)) u_chk (
    .wr_clk  (wr_clk),
    .wr_rst  (wr_rst),
    .rd_clk  (rd_clk),
    .rd_rst  (rd_rst),
    .req     (req_w),
    .ack     (ack_w),
    .ack_s   (ack_at_wr),
    .req_s   (req_at_rd),
    .bus     (bus_w),
    .wr_busy (wr_busy),
    .wr_done (wr_done),
    .rd_done (rd_done)
);

// File: tb/hs4_channel_test.sv
module hs4_channel_test;
    localparam int W = 16;

    logic         wr_clk = 1'b0;
    logic         rd_clk = 1'b0;
    logic         wr_rst = 1'b1;
    logic         rd_rst = 1'b1;
    logic         wr_go  = 1'b0;
    logic [W-1:0] wr_word = '0;
    logic         rd_arm = 1'b0;
    logic         wr_busy, wr_done, rd_done, chan_req, chan_ack;
    logic [W-1:0] rd_word;

    int total = 0;
    int bad   = 0;
    int wr_cnt = 0;
    int rd_cnt = 0;

    always #10 wr_clk = ~wr_clk;   // 50 MHz
    always #17 rd_clk = ~rd_clk;

    hs4_channel #(.WIDTH(W)) uut (
        .wr_clk(wr_clk), .wr_rst(wr_rst), .wr_go(wr_go), .wr_word(wr_word),
        .wr_busy(wr_busy), .wr_done(wr_done),
        .rd_clk(rd_clk), .rd_rst(rd_rst), .rd_arm(rd_arm),
        .rd_word(rd_word), .rd_done(rd_done),
        .chan_req(chan_req), .chan_ack(chan_ack)
    );

    always @(posedge wr_clk) if (!wr_rst && wr_done) wr_cnt <= wr_cnt + 1;
    always @(posedge rd_clk) if (!rd_rst && rd_done) rd_cnt <= rd_cnt + 1;

    // bit 16: arm the reader before the go pulse
    localparam logic [16:0] VEC [6] = '{
        {1'b1, 16'hA5C3}, {1'b0, 16'h0000}, {1'b1, 16'hFFFF},
        {1'b0, 16'h1234}, {1'b1, 16'h8001}, {1'b0, 16'h7E5A}
    };

    task automatic chk(input bit ok, input string tag,
                       input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic go_pulse(input logic [W-1:0] w);
        @(negedge wr_clk);
        wr_word = w;
        wr_go   = 1'b1;
        @(negedge wr_clk);
        wr_go   = 1'b0;
    endtask

    task automatic arm_pulse();
        @(negedge rd_clk);
        rd_arm = 1'b1;
        @(negedge rd_clk);
        rd_arm = 1'b0;
    endtask

    task automatic wr_wait(input int n);
        for (int i = 0; i < n; i++) @(posedge wr_clk);
        #1;
    endtask

    initial begin
        wr_wait(150000);
        bad++;
        total++;
        $display("FAIL watchdog: run did not finish");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int rd0;
        int wr0;
        wr_wait(4);
        // R8: reset state
        chk(chan_req == 1'b0, "R8 req in reset", chan_req, 0);
        chk(chan_ack == 1'b0, "R8 ack in reset", chan_ack, 0);
        chk(wr_busy == 1'b0, "R8 busy in reset", wr_busy, 0);
        chk(wr_done == 1'b0 && rd_done == 1'b0, "R8 done in reset", {wr_done, rd_done}, 0);
        chk(rd_word == '0, "R8 rd_word in reset", rd_word, 0);
        @(negedge wr_clk);
        wr_rst = 1'b0;
        @(negedge rd_clk);
        rd_rst = 1'b0;
        wr_wait(3);

        for (int v = 0; v < 6; v++) begin
            rd0 = rd_cnt;
            wr0 = wr_cnt;
            if (VEC[v][16]) begin
                arm_pulse();
                go_pulse(VEC[v][15:0]);
                wr_word = ~VEC[v][15:0];
                wr_wait(1);
                chk(wr_busy == 1'b1, "R6 busy after go", wr_busy, 1);
            end else begin
                go_pulse(VEC[v][15:0]);
                wr_word = ~VEC[v][15:0];
                wr_wait(30);
                chk(wr_busy == 1'b1, "R5 writer stalls while reader unarmed", wr_busy, 1);
                chk(chan_ack == 1'b0, "R5 no ack while unarmed", chan_ack, 0);
                chk(chan_req == 1'b1, "R1 req held high waiting", chan_req, 1);
                arm_pulse();
            end
            wait (rd_cnt == rd0 + 1);
            #1;
            chk(rd_word == VEC[v][15:0], "R3 received word", rd_word, VEC[v][15:0]);
            chk(chan_ack == 1'b1, "R7 ack high with rd_done", chan_ack, 1);
            wait (wr_cnt == wr0 + 1);
            #1;
            chk(wr_busy == 1'b0, "R6 busy clear at done", wr_busy, 0);
            chk(chan_req == 1'b0 && chan_ack == 1'b0, "R1 channel back to idle",
                {chan_req, chan_ack}, 0);
            wr_wait(1);
            chk(wr_done == 1'b0, "R7 wr_done one cycle", wr_done, 0);
            chk(rd_cnt == rd0 + 1, "R7 single rd_done", rd_cnt - rd0, 1);
        end

        // R4: go while busy is ignored
        rd0 = rd_cnt;
        wr0 = wr_cnt;
        go_pulse(16'h3C3C);
        wr_wait(2);
        go_pulse(16'hC3C3);
        arm_pulse();
        wait (wr_cnt == wr0 + 1);
        #1;
        chk(rd_word == 16'h3C3C, "R4 first word kept", rd_word, 16'h3C3C);
        arm_pulse();
        wr_wait(60);
        chk(chan_req == 1'b0, "R4 no second request", chan_req, 0);
        chk(rd_cnt == rd0 + 1, "R4 one transfer only", rd_cnt - rd0, 1);
        chk(wr_busy == 1'b0, "R4 writer idle", wr_busy, 0);

        // R5: reader armed long before request stays armed (armed just above)
        rd0 = rd_cnt;
        wr0 = wr_cnt;
        go_pulse(16'h5AA5);
        wait (wr_cnt == wr0 + 1);
        #1;
        chk(rd_word == 16'h5AA5, "R5 armed reader captured", rd_word, 16'h5AA5);
        chk(rd_cnt == rd0 + 1, "R5 one capture", rd_cnt - rd0, 1);

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule